// File: doc/BRIEF.md
# Packet Stream Source

This block turns a packet of bytes, loaded into a small local buffer, into a sequence of beats on a valid/ready streaming interface. Software or an upstream engine writes the packet bytes one at a time through a byte-wide write port. It then presents the packet length, a channel number and a gap pattern, and pulses `start`. The block packs the bytes into bus-wide words with the earliest byte in the most significant lane. It marks the first beat with a start-of-packet flag and the final beat with an end-of-packet flag. On the final beat it reports how many byte lanes are unused.

The downstream side can stall any beat by holding `st_ready` low. The handshake uses a ready latency of zero: a beat is taken on an edge where `st_valid` and `st_ready` are both high. An optional on/off pattern makes the source drop `st_valid` for a fixed number of cycles after every group of accepted beats. This throttles the stream without any help from the sink.

A start request is refused, and a one-cycle `reject` pulse is given, in either of two cases: the channel is above the configured ceiling, or the length is zero or larger than the buffer. Whenever no beat is being offered, every payload field reads as zero.

Top module: `pkt_stream_src`

## Requirements
- R1: Byte k of a packet appears in beat k / DATA_BYTES. Within a beat, the lowest-numbered byte occupies `st_data[8*DATA_BYTES-1 -: 8]` and later bytes occupy the lower lanes in turn. Lanes past the end of the packet read zero.
- R2: `st_sop` is high on the first beat of a packet and low on every other beat.
- R3: `st_eop` is high only on the beat that holds the last packet byte. On that beat `st_empty` equals DATA_BYTES minus the number of bytes it carries. On every other beat `st_empty` is 0.
- R4: While `st_valid` is high and `st_ready` is low, the next cycle still offers the same beat, with `st_data`, `st_sop`, `st_eop`, `st_empty` and `st_channel` unchanged.
- R5: With `on_beats` = N and `off_cycles` = M, both non-zero and latched at start, exactly M cycles with `st_valid` low follow every N-th accepted beat of a packet, except after the final beat. If either value is 0, beats follow one another with no gap.
- R6: Every beat carries the `req_chan` value latched at start. A start with `req_chan` greater than MAX_CHAN (default 2^CH_W−1) produces no beats, and `reject` is high for exactly the one cycle after that start.
- R7: A start with `pkt_len` equal to 0 or greater than MAX_LEN is refused in the same way: no beats, and a one-cycle `reject`.
- R8: Whenever `st_valid` is low, `st_data`, `st_empty` and `st_channel` are 0, and `st_sop` and `st_eop` are low.
- R9: While `busy` is high, `start` pulses and buffer writes are ignored. The packet in flight is unchanged and no further packet follows.
- R10: After reset, `st_valid`, `busy` and `reject` are low and all payload outputs are zero.
- R11: The first beat is offered, with `busy` high, in the cycle after an accepted `start` is sampled. `busy` falls in the cycle after the end-of-packet beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Writes `wr_byte` into the buffer at `wr_addr` |
| wr_addr | input | $clog2(MAX_LEN) | Buffer byte address |
| wr_byte | input | 8 | Byte to store |
| start | input | 1 | Requests transmission of the buffered packet |
| pkt_len | input | $clog2(MAX_LEN+DATA_BYTES+1) | Packet length in bytes, sampled with `start` |
| req_chan | input | CH_W | Channel for the packet, sampled with `start` |
| on_beats | input | GW | Beats per run before an idle gap (0 = no gaps) |
| off_cycles | input | GW | Idle cycles per gap (0 = no gaps) |
| st_ready | input | 1 | Sink accepts the current beat |
| st_valid | output | 1 | A beat is offered |
| st_data | output | 8*DATA_BYTES | Beat payload, first byte in the top lane |
| st_sop | output | 1 | First beat of a packet |
| st_eop | output | 1 | Last beat of a packet |
| st_empty | output | max($clog2(DATA_BYTES),1) | Unused lanes on the last beat |
| st_channel | output | CH_W | Channel of the packet |
| busy | output | 1 | A packet is in flight |
| reject | output | 1 | One-cycle pulse after a refused start |

## Verification
The packing logic is tried with a single-byte packet, a packet that is an exact multiple of the bus width, an odd length, and a full-buffer packet. These lengths separate the empty-count arithmetic at its extremes (3 and 0) and show whether lanes past the end are zeroed. The sink is driven both always ready and with a pseudo-random ready pattern, so a beat that slips forward or changes during a stall is caught. Two gap patterns, one beat per run and two beats per run, show whether gaps land after the right beats and have the right length. A final packet gets a mid-flight buffer write and a second start, to show that a live packet cannot be disturbed. Refused starts with a channel just above the limit, a zero length and an oversize length check the admission rules against a channel exactly at the limit, which must pass.

// File: rtl/pkt_src_pkg.sv
package pkt_src_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } src_state_e;

endpackage

// File: rtl/pkt_byte_buf.sv
module pkt_byte_buf #(
    parameter int DATA_BYTES = 4,
    parameter int MAX_LEN    = 64,
    parameter int LW         = 7,
    parameter int EW         = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(MAX_LEN)-1:0] wr_addr,
    input  logic [7:0]                wr_byte,
    input  logic [LW-1:0]             rd_ptr,
    input  logic [LW-1:0]             rd_len,
    output logic [8*DATA_BYTES-1:0]   rd_word,
    output logic                      rd_last,
    output logic [EW-1:0]             rd_empty
);
    localparam int AW = $clog2(MAX_LEN);

    logic [7:0] mem_q [MAX_LEN];
    logic [7:0] mem_d [MAX_LEN];
    logic [LW-1:0] remain;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_LEN; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // lane 0 (top byte) carries the lowest byte offset
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        logic [LW-1:0] idx;
        assign idx = rd_ptr + LW'(i);
        assign rd_word[(DATA_BYTES-1-i)*8 +: 8] =
            ((idx < rd_len) && (idx < LW'(MAX_LEN))) ? mem_q[idx[AW-1:0]] : 8'h00;
    end

    assign remain   = rd_len - rd_ptr;
    assign rd_last  = (remain <= LW'(DATA_BYTES));
    assign rd_empty = rd_last ? EW'(LW'(DATA_BYTES) - remain) : '0;

endmodule

// File: rtl/pkt_gap_ctrl.sv
module pkt_gap_ctrl #(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          beat_acc,
    input  logic          last_beat,
    input  logic [GW-1:0] on_n,
    input  logic [GW-1:0] off_n,
    output logic          gap_start,
    output logic          idle_last
);
    typedef struct packed {
        logic [GW-1:0] run;
        logic [GW-1:0] idle;
    } gap_regs_t;

    gap_regs_t q, d;

    always_comb begin
        d = q;
        gap_start = beat_acc && !last_beat && (on_n != '0) && (off_n != '0)
                    && (q.run == on_n - GW'(1));
        if (clr) begin
            d.run  = '0;
            d.idle = '0;
        end else if (gap_start) begin
            d.run  = '0;
            d.idle = off_n;
        end else if (beat_acc) begin
            d.run  = q.run + GW'(1);
        end else if (q.idle != '0) begin
            d.idle = q.idle - GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle_last = (q.idle == GW'(1));

endmodule

// File: rtl/pkt_stream_src.sv
module pkt_stream_src #(
    parameter int DATA_BYTES = 4,
    parameter int MAX_LEN    = 64,
    parameter int CH_W       = 4,
    parameter int MAX_CHAN   = 2**CH_W - 1,
    parameter int GW         = 4,
    localparam int AW = $clog2(MAX_LEN),
    localparam int LW = $clog2(MAX_LEN + DATA_BYTES + 1),
    localparam int DW = 8 * DATA_BYTES,
    localparam int EW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_byte,
    input  logic            start,
    input  logic [LW-1:0]   pkt_len,
    input  logic [CH_W-1:0] req_chan,
    input  logic [GW-1:0]   on_beats,
    input  logic [GW-1:0]   off_cycles,
    input  logic            st_ready,
    output logic            st_valid,
    output logic [DW-1:0]   st_data,
    output logic            st_sop,
    output logic            st_eop,
    output logic [EW-1:0]   st_empty,
    output logic [CH_W-1:0] st_channel,
    output logic            busy,
    output logic            reject
);
    import pkt_src_pkg::*;

    localparam logic [CH_W-1:0] CHAN_LIM = CH_W'(MAX_CHAN);
    localparam logic [LW-1:0]   STEP     = LW'(DATA_BYTES);

    typedef struct packed {
        src_state_e      state;
        logic [LW-1:0]   ptr;
        logic [LW-1:0]   len;
        logic [CH_W-1:0] chan;
        logic [GW-1:0]   on_n;
        logic [GW-1:0]   off_n;
        logic            valid;
        logic [DW-1:0]   data;
        logic            sop;
        logic            eop;
        logic [EW-1:0]   empty;
        logic [CH_W-1:0] out_chan;
        logic            reject;
    } src_regs_t;

    src_regs_t q, d;

    logic          accept;
    logic          start_ok;
    logic          chan_bad;
    logic          len_bad;
    logic          load_beat;
    logic          blank_beat;
    logic [LW-1:0] rd_ptr;
    logic [LW-1:0] rd_len;
    logic [DW-1:0] rd_word;
    logic          rd_last;
    logic [EW-1:0] rd_empty;
    logic          gap_start;
    logic          idle_last;

    assign accept   = q.valid && st_ready;
    assign chan_bad = (req_chan > CHAN_LIM);
    assign len_bad  = (pkt_len == '0) || (pkt_len > LW'(MAX_LEN));
    assign start_ok = (q.state == ST_IDLE) && start && !chan_bad && !len_bad;
    assign rd_ptr   = (q.state == ST_SEND) ? (q.ptr + STEP) : q.ptr;
    assign rd_len   = (q.state == ST_IDLE) ? pkt_len : q.len;

    pkt_byte_buf #(
        .DATA_BYTES (DATA_BYTES),
        .MAX_LEN    (MAX_LEN),
        .LW         (LW),
        .EW         (EW)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && (q.state == ST_IDLE)),
        .wr_addr  (wr_addr),
        .wr_byte  (wr_byte),
        .rd_ptr   (rd_ptr),
        .rd_len   (rd_len),
        .rd_word  (rd_word),
        .rd_last  (rd_last),
        .rd_empty (rd_empty)
    );

    pkt_gap_ctrl #(
        .GW (GW)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_ok),
        .beat_acc  (accept),
        .last_beat (q.eop),
        .on_n      (q.on_n),
        .off_n     (q.off_n),
        .gap_start (gap_start),
        .idle_last (idle_last)
    );

    always_comb begin
        d          = q;
        d.reject   = 1'b0;
        load_beat  = 1'b0;
        blank_beat = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    if (!start_ok) begin
                        d.reject = 1'b1;
                    end else begin
                        d.state   = ST_SEND;
                        d.len     = pkt_len;
                        d.chan    = req_chan;
                        d.on_n    = on_beats;
                        d.off_n   = off_cycles;
                        d.ptr     = '0;
                        load_beat = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (accept) begin
                    if (q.eop) begin
                        d.state    = ST_IDLE;
                        d.ptr      = '0;
                        blank_beat = 1'b1;
                    end else begin
                        d.ptr = q.ptr + STEP;
                        if (gap_start) begin
                            d.state    = ST_GAP;
                            blank_beat = 1'b1;
                        end else begin
                            load_beat = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (idle_last) begin
                    d.state   = ST_SEND;
                    load_beat = 1'b1;
                end
            end
            default: begin
                d.state    = ST_IDLE;
                d.ptr      = '0;
                blank_beat = 1'b1;
            end
        endcase

        if (load_beat) begin
            d.valid    = 1'b1;
            d.data     = rd_word;
            d.eop      = rd_last;
            d.empty    = rd_empty;
            d.sop      = (q.state == ST_IDLE);
            d.out_chan = (q.state == ST_IDLE) ? req_chan : q.chan;
        end
        if (blank_beat) begin
            d.valid    = 1'b0;
            d.data     = '0;
            d.eop      = 1'b0;
            d.empty    = '0;
            d.sop      = 1'b0;
            d.out_chan = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign st_valid   = q.valid;
    assign st_data    = q.data;
    assign st_sop     = q.sop;
    assign st_eop     = q.eop;
    assign st_empty   = q.empty;
    assign st_channel = q.out_chan;
    assign busy       = (q.state != ST_IDLE);
    assign reject     = q.reject;

endmodule

// File: rtl/pkt_stream_src_chk.sv
module pkt_stream_src_chk #(
    parameter int DW       = 32,
    parameter int EW       = 2,
    parameter int CH_W     = 4,
    parameter int MAX_CHAN = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic            st_ready,
    input logic            st_valid,
    input logic [DW-1:0]   st_data,
    input logic            st_sop,
    input logic            st_eop,
    input logic [EW-1:0]   st_empty,
    input logic [CH_W-1:0] st_channel,
    input logic            busy,
    input logic            reject
);
    localparam logic [CH_W-1:0] CHAN_LIM = CH_W'(MAX_CHAN);

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_sop)
            && $stable(st_eop) && $stable(st_empty) && $stable(st_channel))); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> (st_data == '0 && !st_sop && !st_eop && st_empty == '0
            && st_channel == '0)); // R8

    AST_EMPTY_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_eop) |-> (st_empty == '0)); // R3

    AST_CHAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_channel <= CHAN_LIM)); // R6

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (!busy && !st_valid)); // R7

    AST_FIRST_IS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (st_valid && st_sop)); // R11

    AST_VALID_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> busy); // R11

endmodule

bind pkt_stream_src pkt_stream_src_chk #(
    .DW       (DW),
    .EW       (EW),
    .CH_W     (CH_W),
    .MAX_CHAN (MAX_CHAN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_ready   (st_ready),
    .st_valid   (st_valid),
    .st_data    (st_data),
    .st_sop     (st_sop),
    .st_eop     (st_eop),
    .st_empty   (st_empty),
    .st_channel (st_channel),
    .busy       (busy),
    .reject     (reject)
);

// File: tb/pkt_stream_src_bench.sv
module pkt_stream_src_bench;
    localparam int DB  = 4;
    localparam int ML  = 16;
    localparam int CHW = 4;
    localparam int MCH = 9;
    localparam int GW  = 4;
    localparam int AW  = $clog2(ML);
    localparam int LW  = $clog2(ML + DB + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [7:0]      wr_byte = '0;
    logic            start = 1'b0;
    logic [LW-1:0]   pkt_len = '0;
    logic [CHW-1:0]  req_chan = '0;
    logic [GW-1:0]   on_beats = '0;
    logic [GW-1:0]   off_cycles = '0;
    logic            st_ready = 1'b1;
    logic            st_valid;
    logic [8*DB-1:0] st_data;
    logic            st_sop;
    logic            st_eop;
    logic [1:0]      st_empty;
    logic [CHW-1:0]  st_channel;
    logic            busy;
    logic            reject;

    always #10 clk = ~clk;

    pkt_stream_src #(
        .DATA_BYTES (DB),
        .MAX_LEN    (ML),
        .CH_W       (CHW),
        .MAX_CHAN   (MCH),
        .GW         (GW)
    ) u_pkt_stream_src (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_byte, .start, .pkt_len, .req_chan,
        .on_beats, .off_cycles, .st_ready, .st_valid, .st_data, .st_sop, .st_eop,
        .st_empty, .st_channel, .busy, .reject
    );

    typedef struct {
        logic [8*DB-1:0] data;
        logic            sop;
        logic            eop;
        logic [1:0]      empty;
        logic [CHW-1:0]  chan;
        int              gap;
    } beat_t;

    beat_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    ready_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ready driver: always-ready or pseudo-random
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (ready_mode == 0) begin
                st_ready = 1'b1;
            end else begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                st_ready = lfsr[0] | lfsr[2];
            end
        end
    end

    // monitor: scoreboard pop and compare
    initial begin
        logic            p_valid = 1'b0;
        logic            p_ready = 1'b0;
        logic [8*DB-1:0] p_data  = '0;
        logic            p_sop = 1'b0, p_eop = 1'b0;
        logic [1:0]      p_empty = '0;
        logic [CHW-1:0]  p_chan = '0;
        bit              want_idle = 0;
        int              idle_cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                p_valid = 1'b0;
                continue;
            end
            if (want_idle) begin
                chk(!busy && !st_valid, "R11", "busy after last beat", {busy, st_valid}, 0);
                want_idle = 0;
            end
            if (p_valid && !p_ready) begin
                chk(st_valid && st_data == p_data && st_sop == p_sop && st_eop == p_eop
                    && st_empty == p_empty && st_channel == p_chan,
                    "R4", "stalled beat changed", st_data, p_data);
            end
            if (!st_valid) begin
                chk(st_data == '0 && !st_sop && !st_eop && st_empty == '0 && st_channel == '0,
                    "R8", "idle fields", {st_data, st_sop, st_eop, st_empty, st_channel}, 0);
                idle_cnt++;
            end else if (st_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected beat", st_data, 0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(st_data == e.data, "R1", "data", st_data, e.data);
                    chk(st_sop == e.sop, "R2", "sop", st_sop, e.sop);
                    chk(st_eop == e.eop && st_empty == e.empty, "R3", "eop/empty",
                        {st_eop, st_empty}, {e.eop, e.empty});
                    chk(st_channel == e.chan, "R6", "channel", st_channel, e.chan);
                    if (!e.sop) begin
                        chk(idle_cnt == e.gap, "R5", "gap length", idle_cnt, e.gap);
                    end
                    if (st_eop) want_idle = 1;
                end
                idle_cnt = 0;
            end
            p_valid = st_valid;
            p_ready = st_ready;
            p_data  = st_data;
            p_sop   = st_sop;
            p_eop   = st_eop;
            p_empty = st_empty;
            p_chan  = st_channel;
        end
    end

    function automatic logic [7:0] pbyte(input int len, input int i, input int chan);
        return 8'(len * 17 + i * 29 + chan * 5 + 3);
    endfunction

    task automatic launch(input int len, input int chan, input int on_n, input int off_n,
                          input bit ok, input string tag);
        while (busy) @(posedge clk);
        for (int i = 0; i < len && i < ML; i++) begin
            @(posedge clk);
            #2;
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_byte = pbyte(len, i, chan);
        end
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        if (ok) begin
            int nb;
            nb = (len + DB - 1) / DB;
            for (int k = 0; k < nb; k++) begin
                beat_t e;
                e.data = '0;
                for (int b = 0; b < DB; b++) begin
                    if (k * DB + b < len)
                        e.data[(DB-1-b)*8 +: 8] = pbyte(len, k * DB + b, chan);
                end
                e.sop   = (k == 0);
                e.eop   = (k == nb - 1);
                e.empty = (k == nb - 1) ? 2'(nb * DB - len) : 2'd0;
                e.chan  = CHW'(chan);
                e.gap   = (on_n != 0 && off_n != 0 && k != 0 && (k % on_n) == 0) ? off_n : 0;
                exp_q.push_back(e);
            end
        end
        start      = 1'b1;
        pkt_len    = LW'(len);
        req_chan   = CHW'(chan);
        on_beats   = GW'(on_n);
        off_cycles = GW'(off_n);
        @(posedge clk);
        #2;
        start = 1'b0;
        @(negedge clk);
        if (ok) begin
            chk(busy && st_valid && st_sop, "R11", "first beat timing",
                {busy, st_valid, st_sop}, 3'b111);
        end else begin
            chk(reject && !busy && !st_valid, tag, "refused start", {reject, busy, st_valid}, 3'b100);
            @(negedge clk);
            chk(!reject && !busy && !st_valid, tag, "reject one cycle, no beat",
                {reject, busy, st_valid}, 0);
        end
    endtask

    task automatic finish_pkt(input string tag);
        while (busy) @(posedge clk);
        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, tag, "beats left over", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!st_valid && !busy && !reject && st_data == '0 && st_empty == '0
            && st_channel == '0 && !st_sop && !st_eop, "R10", "reset state",
            {st_valid, busy, reject, st_data}, 0);

        // single byte: empty 3, sop and eop together
        launch(1, 0, 0, 0, 1, "R1");
        finish_pkt("R3");
        // exact multiple of the bus width: empty 0
        launch(8, 5, 0, 0, 1, "R1");
        finish_pkt("R3");
        // odd length, channel at the limit, random stalls
        ready_mode = 1;
        launch(13, 9, 0, 0, 1, "R6");
        finish_pkt("R4");
        // full buffer with one-beat runs and 2-cycle gaps
        ready_mode = 0;
        launch(16, 2, 1, 2, 1, "R5");
        finish_pkt("R5");
        // two-beat runs with 1-cycle gaps under stalls
        ready_mode = 1;
        launch(11, 7, 2, 1, 1, "R5");
        finish_pkt("R5");
        // gap disabled by off = 0
        ready_mode = 0;
        launch(12, 1, 1, 0, 1, "R5");
        finish_pkt("R5");
        // refused starts
        launch(4, 10, 0, 0, 0, "R6");
        launch(0, 1, 0, 0, 0, "R7");
        launch(17, 1, 0, 0, 0, "R7");
        // disturbance while in flight
        ready_mode = 1;
        launch(16, 3, 1, 3, 1, "R9");
        @(posedge clk);
        #2;
        chk(busy, "R9", "still busy before disturbance", busy, 1);
        wr_en = 1'b1; wr_addr = AW'(14); wr_byte = 8'hEE;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
        start = 1'b1; pkt_len = LW'(4); req_chan = CHW'(1);
        @(posedge clk);
        #2;
        start = 1'b0;
        finish_pkt("R9");
        ready_mode = 0;
        repeat (4) @(negedge clk);
        chk(!busy && !st_valid, "R9", "no second packet", {busy, st_valid}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule